// File: doc/BRIEF.md
# Spline-Point Waveform Stage

This block passes an analog waveform between emulation models as a short list of fixed-point spline points. The list covers one emulation time step whose length varies from step to step. An upstream model hands over a set of four points. Each point is the waveform value at a fixed fraction of the longest step the models may take. The stage reshapes every point on its own through a static transfer curve and keeps the reshaped set. Downstream logic reads that set back, with any point that lies beyond the granted step removed.

In every cycle the stage also takes the step length that the scheduler granted and a time offset inside that step. It reports the reshaped waveform at that offset by drawing straight lines between neighbouring points. Time is counted in ticks. The longest step is 49152 ticks, and point k sits at tick k*16384. Point values are signed 16-bit numbers with 12 fractional bits, so one unit is 4096.

Top module: `spl_wave_stage`

## Requirements
- R1: A point set is taken in on a rising edge where in_valid and in_ready are both high. After that edge in_ready stays low for exactly one cycle and then returns high.
- R2: The stored point set changes only as the result of an accepted set. in_pts with in_valid low, or in_valid while in_ready is low, leave out_pts unchanged.
- R3: Each stored point is the transfer curve applied to the matching input point, and it keeps the same position. Point k sits in bits [16k+15:16k] of both in_pts and out_pts. The curve is identity for inputs in [-2.0, 2.0]. Between 2.0 and 4.0 in magnitude it gives sign*(2.0 + (|x|-2.0)/2), rounded toward minus infinity in units of 2^-12.
- R4: Inputs beyond 4.0 in magnitude saturate, to 12288 (3.0) at the top and to -12288 at the bottom. This includes the extreme codes 0x7FFF and 0x8000.
- R5: A grant above 49152 raises out_err and is treated as 49152. A grant of 49152 or less leaves out_err low.
- R6: out_keep bit k is 1 for k = 0. For k > 0 it is 1 when the clamped grant is greater than (k-1)*16384. Dropped points read as zero on out_pts, and they never contribute to out_val.
- R7: For a clamped time t, let s = t / 16384 and f = t mod 16384. Then out_val = p[s] + floor((p[s+1]-p[s])*f / 16384). At t = 49152 the result is p[3].
- R8: An evaluation time later than the clamped grant is evaluated at the clamped grant.
- R9: out_val, out_keep and out_err reflect grant and eval_t two rising edges after those inputs are applied. A newly accepted set first affects out_val three edges after the accepting edge.
- R10: While reset is held and just after it is released, in_ready is high and out_val, out_keep, out_err and out_pts are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| in_valid | input | 1 | Upstream offers a point set |
| in_ready | output | 1 | Stage can take a point set |
| in_pts | input | 64 | Four Q4.12 input points, point k in bits [16k+15:16k] |
| grant | input | 16 | Granted step length in ticks |
| eval_t | input | 16 | Requested time offset in ticks |
| out_val | output | 16 | Interpolated Q4.12 value at the clamped time |
| out_pts | output | 64 | Reshaped points, with dropped points forced to zero |
| out_keep | output | 4 | Mask of the points inside the granted step |
| out_err | output | 1 | Grant exceeded the longest step |

## Verification
A point-set commit and an evaluation can land in the same cycle. The evaluation then reads the stored points on the very edge where they are replaced. The bench provokes this by holding grant and eval_t steady while it accepts a set whose first point differs from the stored one. It then checks that out_val keeps the old value for three edges and shows the new value on the third. A table of grant and time vectors covers clamping, dropped points and rounding for negative slopes.

// File: rtl/spl_pkg.sv
package spl_pkg;

  localparam int SPL_NPTS    = 4;
  localparam int SPL_DW      = 16;
  localparam int SPL_FRAC    = 12;
  localparam int SPL_TW      = 16;
  localparam int SPL_SEG_LOG = 14;
  localparam int SPL_LIN     = 2;
  localparam int SPL_SAT     = 4;

  // Transfer curve value at integer input k, returned in fixed point.
  function automatic int spl_knot(input int k, input int lin, input int sat,
                                  input int frac);
    int mag;
    int res;
    mag = (k < 0) ? -k : k;
    if (mag <= lin)
      res = mag <<< frac;
    else if (mag <= sat)
      res = (lin <<< frac) + ((mag - lin) <<< (frac - 1));
    else
      res = (lin <<< frac) + ((sat - lin) <<< (frac - 1));
    return (k < 0) ? -res : res;
  endfunction

endpackage

// File: rtl/spl_shaper.sv
module spl_shaper
  import spl_pkg::*;
#(
  parameter int DW   = SPL_DW,
  parameter int FRAC = SPL_FRAC,
  parameter int LIN  = SPL_LIN,
  parameter int SAT  = SPL_SAT
) (
  input  logic signed [DW-1:0] x,
  output logic signed [DW-1:0] y
);

  localparam int IW    = DW - FRAC;
  localparam int NSEG  = 1 << IW;
  localparam int HALF  = NSEG / 2;
  localparam int SAT_Q = spl_knot(HALF, LIN, SAT, FRAC);

  int knot [NSEG+1];

  for (genvar g = 0; g <= NSEG; g++) begin : g_knot
    assign knot[g] = spl_knot(g - HALF, LIN, SAT, FRAC);
  end

  logic [IW:0]     idx_lo;
  logic [IW:0]     idx_hi;
  logic [FRAC-1:0] fr;
  int              lo_v;
  int              hi_v;
  int              prod_v;
  int              sum_v;

  always_comb begin
    idx_lo = {1'b0, ~x[DW-1], x[DW-2:FRAC]};
    idx_hi = idx_lo + (IW+1)'(1);
    fr     = x[FRAC-1:0];
    lo_v   = knot[idx_lo];
    hi_v   = knot[idx_hi];
    prod_v = (hi_v - lo_v) * int'(fr);
    sum_v  = lo_v + (prod_v >>> FRAC);
    y      = DW'(sum_v);
    assert_nl_sat_R4: assert ((sum_v <= SAT_Q) && (sum_v >= -SAT_Q));
  end

endmodule

// File: rtl/spl_pointbuf.sv
module spl_pointbuf
  import spl_pkg::*;
#(
  parameter int NPTS = SPL_NPTS,
  parameter int DW   = SPL_DW,
  parameter int FRAC = SPL_FRAC,
  parameter int LIN  = SPL_LIN,
  parameter int SAT  = SPL_SAT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NPTS*DW-1:0]   in_pts,
  output logic [NPTS*DW-1:0]   held_pts
);

  localparam int BW = NPTS * DW;

  logic          pend_q;
  logic          pend_d;
  logic          accept;
  logic          raw_en;
  logic          held_en;
  logic [BW-1:0] raw_q;
  logic [BW-1:0] held_q;
  logic [BW-1:0] shaped;

  for (genvar g = 0; g < NPTS; g++) begin : g_shape
    spl_shaper #(
      .DW(DW), .FRAC(FRAC), .LIN(LIN), .SAT(SAT)
    ) u_shp (
      .x(raw_q[g*DW +: DW]),
      .y(shaped[g*DW +: DW])
    );
  end

  always_comb begin
    in_ready = ~pend_q;
    accept   = in_valid & ~pend_q;
    pend_d   = accept;
    raw_en   = accept;
    held_en  = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      raw_q  <= '0;
      held_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (raw_en)  raw_q  <= in_pts;
      if (held_en) held_q <= shaped;
    end
  end

  assign held_pts = held_q;

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_ready_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(held_pts));

endmodule

// File: rtl/spl_eval.sv
module spl_eval
  import spl_pkg::*;
#(
  parameter int NPTS    = SPL_NPTS,
  parameter int DW      = SPL_DW,
  parameter int TW      = SPL_TW,
  parameter int SEG_LOG = SPL_SEG_LOG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NPTS*DW-1:0]      held_pts,
  input  logic [TW-1:0]           grant,
  input  logic [TW-1:0]           eval_t,
  output logic signed [DW-1:0]    out_val,
  output logic [NPTS-1:0]         out_keep,
  output logic                    out_err
);

  localparam int            SW      = $clog2(NPTS);
  localparam logic [TW-1:0] MAXSTEP = TW'((NPTS - 1) << SEG_LOG);

  logic signed [DW-1:0] pt [NPTS];

  for (genvar g = 0; g < NPTS; g++) begin : g_unpack
    assign pt[g] = held_pts[g*DW +: DW];
  end

  logic                 over;
  logic [TW-1:0]        g_eff;
  logic [TW-1:0]        t_eff;
  logic [NPTS-1:0]      keep;
  logic [SW-1:0]        seg;
  logic [SEG_LOG-1:0]   frac;
  logic signed [DW-1:0] lo;
  logic signed [DW-1:0] hi;
  logic                 hi_kept;

  assign over  = grant > MAXSTEP;
  assign g_eff = over ? MAXSTEP : grant;
  assign t_eff = (eval_t > g_eff) ? g_eff : eval_t;

  for (genvar k = 0; k < NPTS; k++) begin : g_keep
    if (k == 0) begin : g_first
      assign keep[k] = 1'b1;
    end else begin : g_rest
      assign keep[k] = g_eff > TW'((k - 1) << SEG_LOG);
    end
  end

  always_comb begin
    seg  = SW'(t_eff >> SEG_LOG);
    frac = t_eff[SEG_LOG-1:0];
    lo   = pt[seg];
    if (seg == SW'(NPTS - 1)) begin
      hi_kept = 1'b0;
      hi      = lo;
    end else begin
      hi_kept = keep[seg + SW'(1)];
      hi      = hi_kept ? pt[seg + SW'(1)] : lo;
    end
  end

  // Stage 1: segment endpoints and weight
  logic signed [DW-1:0] s1_lo;
  logic signed [DW-1:0] s1_hi;
  logic [SEG_LOG-1:0]   s1_frac;
  logic [NPTS-1:0]      s1_keep;
  logic                 s1_err;
  logic                 s1_en;

  // Stage 2: interpolated value
  logic signed [DW-1:0] val_d;
  logic signed [DW-1:0] val_q;
  logic [NPTS-1:0]      keep_q;
  logic                 err_q;
  logic                 s2_en;
  logic signed [DW-1:0] s1_min;
  logic signed [DW-1:0] s1_max;
  int                   diff_v;
  int                   prod_v;

  always_comb begin
    s1_en  = 1'b1;
    s2_en  = 1'b1;
    diff_v = int'(s1_hi) - int'(s1_lo);
    prod_v = diff_v * int'(s1_frac);
    val_d  = DW'(int'(s1_lo) + (prod_v >>> SEG_LOG));
    s1_min = (s1_lo < s1_hi) ? s1_lo : s1_hi;
    s1_max = (s1_lo < s1_hi) ? s1_hi : s1_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_lo   <= '0;
      s1_hi   <= '0;
      s1_frac <= '0;
      s1_keep <= '0;
      s1_err  <= 1'b0;
    end else if (s1_en) begin
      s1_lo   <= lo;
      s1_hi   <= hi;
      s1_frac <= frac;
      s1_keep <= keep;
      s1_err  <= over;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      keep_q <= '0;
      err_q  <= 1'b0;
    end else if (s2_en) begin
      val_q  <= val_d;
      keep_q <= s1_keep;
      err_q  <= s1_err;
    end
  end

  assign out_val  = val_q;
  assign out_keep = keep_q;
  assign out_err  = err_q;

  assert_err_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant > MAXSTEP) |-> ##2 out_err);

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant <= MAXSTEP) |-> ##2 !out_err);

  assert_keep_therm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_keep & (out_keep + NPTS'(1))) == '0);

  assert_keep_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ##2 out_keep[0]);

  assert_drop_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_kept |-> (frac == '0));

  assert_val_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((out_val >= $past(s1_min)) && (out_val <= $past(s1_max))));

endmodule

// File: rtl/spl_wave_stage.sv
module spl_wave_stage
  import spl_pkg::*;
#(
  parameter int NPTS    = SPL_NPTS,
  parameter int DW      = SPL_DW,
  parameter int FRAC    = SPL_FRAC,
  parameter int TW      = SPL_TW,
  parameter int SEG_LOG = SPL_SEG_LOG,
  parameter int LIN     = SPL_LIN,
  parameter int SAT     = SPL_SAT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [NPTS*DW-1:0]    in_pts,
  input  logic [TW-1:0]         grant,
  input  logic [TW-1:0]         eval_t,
  output logic signed [DW-1:0]  out_val,
  output logic [NPTS*DW-1:0]    out_pts,
  output logic [NPTS-1:0]       out_keep,
  output logic                  out_err
);

  logic                 rst_meta_q;
  logic                 rst_sync_q;
  logic [NPTS*DW-1:0]   held_pts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  spl_pointbuf #(
    .NPTS(NPTS), .DW(DW), .FRAC(FRAC), .LIN(LIN), .SAT(SAT)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_pts  (in_pts),
    .held_pts(held_pts)
  );

  spl_eval #(
    .NPTS(NPTS), .DW(DW), .TW(TW), .SEG_LOG(SEG_LOG)
  ) u_eval (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .held_pts(held_pts),
    .grant   (grant),
    .eval_t  (eval_t),
    .out_val (out_val),
    .out_keep(out_keep),
    .out_err (out_err)
  );

  for (genvar g = 0; g < NPTS; g++) begin : g_mask
    assign out_pts[g*DW +: DW] = out_keep[g] ? held_pts[g*DW +: DW] : '0;
  end

endmodule

// File: tb/spl_wave_stage_test.sv
`timescale 1ns/1ps
module spl_wave_stage_test;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic               in_ready;
  logic [63:0]        in_pts;
  logic [15:0]        grant;
  logic [15:0]        eval_t;
  logic signed [15:0] out_val;
  logic [63:0]        out_pts;
  logic [3:0]         out_keep;
  logic               out_err;

  int n_checks;
  int n_fails;
  bit done;

  spl_wave_stage uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pts(in_pts), .grant(grant), .eval_t(eval_t), .out_val(out_val),
    .out_pts(out_pts), .out_keep(out_keep), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0]        g;
    logic [15:0]        t;
    logic signed [15:0] v;
    logic [3:0]         k;
    logic               e;
  } vec_t;

  // Reshaped set A is {0, 4096, 10240, -12288}.
  localparam vec_t VEC [13] = '{
    '{16'd49152, 16'd0,     16'sd0,      4'b1111, 1'b0},
    '{16'd49152, 16'd8192,  16'sd2048,   4'b1111, 1'b0},
    '{16'd49152, 16'd16384, 16'sd4096,   4'b1111, 1'b0},
    '{16'd49152, 16'd24576, 16'sd7168,   4'b1111, 1'b0},
    '{16'd49152, 16'd40960, -16'sd1024,  4'b1111, 1'b0},
    '{16'd49152, 16'd49152, -16'sd12288, 4'b1111, 1'b0},
    '{16'd60000, 16'd65535, -16'sd12288, 4'b1111, 1'b1},
    '{16'd20000, 16'd30000, 16'sd5452,   4'b0111, 1'b0},
    '{16'd16384, 16'd16384, 16'sd4096,   4'b0011, 1'b0},
    '{16'd0,     16'd5000,  16'sd0,      4'b0001, 1'b0},
    '{16'd49153, 16'd100,   16'sd25,     4'b1111, 1'b1},
    '{16'd40000, 16'd36864, 16'sd4608,   4'b1111, 1'b0},
    '{16'd49152, 16'd32769, 16'sd10238,  4'b1111, 1'b0}
  };

  localparam logic [63:0] SET_A  = {16'hB000, 16'h3000, 16'h1000, 16'h0000};
  localparam logic [63:0] SET_B  = {16'hDFFF, 16'h2800, 16'h8000, 16'h7FFF};
  localparam logic [63:0] JUNK   = {16'h1234, 16'h2345, 16'h3456, 16'h4567};
  localparam int          A_T [4] = '{0, 4096, 10240, -12288};
  localparam int          B_T [4] = '{12288, -12288, 9216, -8193};

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pt_of(input int k);
    return int'($signed(out_pts[k*16 +: 16]));
  endfunction

  task automatic load_set(input logic [63:0] pts);
    @(negedge clk);
    in_valid = 1'b1;
    in_pts   = pts;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    done     = 1'b0;
    n_checks = 0;
    n_fails  = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_pts   = '0;
    grant    = 16'd49152;
    eval_t   = 16'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    settle(3);
    chk("R10 out_val", int'(out_val), 0);
    chk("R10 out_keep", int'(out_keep), 0);
    chk("R10 out_err", int'(out_err), 0);
    chk("R10 out_pts", int'(out_pts != 64'd0), 0);
    chk("R10 in_ready", int'(in_ready), 1);

    // R1 and R2: handshake, and an offer while not ready is dropped
    @(negedge clk);
    in_valid = 1'b1;
    in_pts   = SET_A;
    @(posedge clk);
    @(negedge clk);
    chk("R1 ready low after accept", int'(in_ready), 0);
    in_pts = JUNK;
    @(posedge clk);
    @(negedge clk);
    chk("R1 ready back high", int'(in_ready), 1);
    in_valid = 1'b0;
    in_pts   = SET_B;
    settle(4);
    for (int k = 0; k < 4; k++) chk("R2 R3 set A point", pt_of(k), A_T[k]);
    in_pts = JUNK;
    settle(3);
    chk("R2 idle input ignored", pt_of(1), A_T[1]);

    // R5..R8 table walk
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      grant  = VEC[i].g;
      eval_t = VEC[i].t;
      settle(2);
      chk("R7 R8 out_val", int'(out_val), int'(VEC[i].v));
      chk("R6 out_keep", int'(out_keep), int'(VEC[i].k));
      chk("R5 out_err", int'(out_err), int'(VEC[i].e));
      for (int k = 0; k < 4; k++)
        chk("R6 out_pts masked", pt_of(k), VEC[i].k[k] ? A_T[k] : 0);
    end

    // R9: output latency of two edges
    @(negedge clk);
    grant  = 16'd49152;
    eval_t = 16'd16384;
    settle(3);
    chk("R9 steady value", int'(out_val), 4096);
    eval_t = 16'd8192;
    settle(1);
    chk("R9 one edge later unchanged", int'(out_val), 4096);
    settle(1);
    chk("R9 two edges later updated", int'(out_val), 2048);

    // R3 and R4: curve knees, odd codes and both saturation ends
    load_set(SET_B);
    settle(4);
    for (int k = 0; k < 4; k++) chk("R3 R4 set B point", pt_of(k), B_T[k]);
    eval_t = 16'd0;
    settle(3);
    chk("R4 value at t0", int'(out_val), 12288);

    // Set commit coinciding with a steady evaluation (R9)
    @(negedge clk);
    in_valid = 1'b1;
    in_pts   = SET_A;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 commit edge+0", int'(out_val), 12288);
    settle(1);
    chk("R9 commit edge+1", int'(out_val), 12288);
    settle(1);
    chk("R9 commit edge+2", int'(out_val), 12288);
    settle(1);
    chk("R9 commit edge+3", int'(out_val), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule